// File: doc/BRIEF.md
# Four-Phase 16-bit Register Machine Core

This core executes a compact 16-bit instruction set. It has sixteen general registers, an 8-bit program counter, and one 256-word memory port that carries both instruction fetches and data accesses. Every instruction takes exactly four clock cycles, stepped by a 2-bit phase counter:

- two fetch phases;
- one operand phase, where the ALU and the jump test are evaluated and any memory data access is issued;
- one commit phase, where the program counter advances and the destination register is written.

The memory is external to the core. It is a synchronous single-port RAM: it returns the word at the presented address one clock after the address is sampled, and it performs a write on the edge where the write enable is sampled high. Because register 0 always reads as zero, two useful forms come for free. An add with register 0 as second source acts as a register copy. A zero-test jump on register 0 acts as an unconditional jump.

Top module: `mc16_core`

## Requirements
- R1: After a synchronous active-high reset, `mem_addr` is 0x00 and `mem_we` is low, so the first instruction is fetched from address 0.
- R2: Each instruction takes four cycles. Its fetch address stays on `mem_addr` for the first two cycles. The next instruction's fetch address appears in the fifth cycle. For any instruction that is not a memory access, `mem_addr` keeps the fetch address for all four cycles.
- R3: The instruction word is laid out as follows: bits [15:12] hold the opcode, [11:8] the destination/tested/transfer register, [7:4] the first source, [3:0] the second source. Immediate forms use [7:0].
- R4: Opcodes 0x0, 0x1, 0x2, 0x4, 0x5 and 0x6 write add, subtract, multiply (low 16 bits of the product), AND, OR and XNOR of the two sources to the destination.
- R5: Opcode 0x3 writes the unsigned quotient. A zero divisor writes 0xFFFF.
- R6: Opcode 0x7 writes the 8-bit immediate, zero-extended, to the destination.
- R7: Opcodes 0x8, 0x9, 0xA and 0xB jump to the immediate when the tested register is zero, nonzero, signed greater than zero, or signed less than zero. A taken jump fetches next from the immediate; otherwise the PC steps by one.
- R8: Register 0 reads as zero. Adding register 0 copies a register, and opcode 0x8 on register 0 is always taken.
- R9: A write aimed at register 0 (arithmetic, move or load) has no effect.
- R10: Opcode 0xC loads the register from memory at the immediate address. Opcode 0xD loads it from memory at the low 8 bits of its own value.
- R11: Opcode 0xE stores the register at the immediate address. Opcode 0xF stores it at the low 8 bits of its own value. `mem_we` is high for exactly one cycle, the third of the instruction, with the register value on `mem_wdata`.
- R12: The 8-bit PC wraps from 0xFF to 0x00.
- R13: Reset clears all sixteen registers as well as the PC and phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Registered memory address (fetch or data) |
| mem_we | output | 1 | Registered memory write enable |
| mem_wdata | output | 16 | Registered memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |

## Verification
A behavioural instruction-level model runs in lockstep with the core and predicts the memory port for each of the four phases:

| Phase | Expected port state |
|-------|---------------------|
| First two | The fetch address |
| Third | The data address and, for stores, the write strobe and data |
| Fourth | The same data address with the strobe low |

Every cycle's sample is taken on the falling edge, after all registers on the path have settled. Register results are made visible by storing them. The final memory image is then checked against hand-computed values, so each arithmetic, load and reset result is confirmed one full instruction after the store that exposes it.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 8;
  localparam int REG_N  = 16;
  localparam int RIDX_W = $clog2(REG_N);

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XNOR = 4'h6,
    OP_MOVI = 4'h7,
    OP_JZ   = 4'h8,
    OP_JNZ  = 4'h9,
    OP_JPOS = 4'hA,
    OP_JNEG = 4'hB,
    OP_LDI  = 4'hC,
    OP_LDR  = 4'hD,
    OP_STI  = 4'hE,
    OP_STR  = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH0 = 2'd0,
    PH_FETCH1 = 2'd1,
    PH_EXEC   = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  input  logic [IDX_W-1:0] raddr_c,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b,
  output logic [WIDTH-1:0] rdata_c
);
  logic [WIDTH-1:0] regs_q [DEPTH];

  // Entry 0 is never written, so it stays at its reset value of zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else if (we && waddr != '0) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
  assign rdata_c = (raddr_c == '0) ? '0 : regs_q[raddr_c];

  // R9: a write aimed at entry 0 leaves it untouched
  p_r0_untouched_r9: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> (regs_q[0] == '0));

  // R4: a write to any other entry lands in the next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 8
) (
  input  opcode_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    y = '0;
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = (b == '0) ? '1 : a / b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XNOR: y = ~(a ^ b);
      OP_MOVI: y = {{(WIDTH-IMM_W){1'b0}}, imm};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc16_brcond.sv
module mc16_brcond
  import mc16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  opcode_e          op,
  input  logic [WIDTH-1:0] val,
  output logic             take
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (val == '0);
  assign is_neg  = val[WIDTH-1];

  always_comb begin
    case (op)
      OP_JZ:   take = is_zero;
      OP_JNZ:  take = !is_zero;
      OP_JPOS: take = !is_zero && !is_neg;
      OP_JNEG: take = is_neg;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int IMM_W = ADDR_W;

  phase_e            ph_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic [WORD_W-1:0] res_q;
  logic              take_q;

  // Fields of the latched instruction
  opcode_e           op_ir;
  logic [RIDX_W-1:0] d_ir;
  logic [RIDX_W-1:0] a_ir;
  logic [RIDX_W-1:0] b_ir;
  logic [IMM_W-1:0]  imm_ir;
  assign op_ir  = opcode_e'(ir_q[15:12]);
  assign d_ir   = ir_q[11:8];
  assign a_ir   = ir_q[7:4];
  assign b_ir   = ir_q[3:0];
  assign imm_ir = ir_q[IMM_W-1:0];

  // Fields of the word arriving from the fetch (valid in the second phase)
  logic [RIDX_W-1:0] d_in;
  logic              mem_op_in;
  logic              store_in;
  logic              reg_addr_in;
  assign d_in        = mem_rdata[11:8];
  assign mem_op_in   = (mem_rdata[15:14] == 2'b11);
  assign store_in    = (mem_rdata[15:13] == 3'b111);
  assign reg_addr_in = mem_rdata[12];

  logic [WORD_W-1:0] rd_a, rd_b, rd_c;
  logic [RIDX_W-1:0] raddr_c;
  assign raddr_c = (ph_q == PH_FETCH1) ? d_in : d_ir;

  logic [ADDR_W-1:0] data_addr_in;
  assign data_addr_in = reg_addr_in ? rd_c[ADDR_W-1:0] : mem_rdata[IMM_W-1:0];

  // Writeback: arithmetic/move (opcode MSB clear) or loads (110x)
  logic              is_load_ir;
  logic              wb_en;
  logic [WORD_W-1:0] wb_data;
  assign is_load_ir = (ir_q[15:13] == 3'b110);
  assign wb_en      = (ph_q == PH_COMMIT) && (!ir_q[15] || is_load_ir);
  assign wb_data    = is_load_ir ? mem_rdata : res_q;

  logic [WORD_W-1:0] alu_y;
  logic              br_take;
  logic [ADDR_W-1:0] next_pc;
  assign next_pc = take_q ? imm_ir : pc_q + 1'b1;

  mc16_regfile #(.WIDTH(WORD_W), .DEPTH(REG_N), .IDX_W(RIDX_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_en),
    .waddr   (d_ir),
    .wdata   (wb_data),
    .raddr_a (a_ir),
    .raddr_b (b_ir),
    .raddr_c (raddr_c),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .rdata_c (rd_c)
  );

  mc16_alu #(.WIDTH(WORD_W), .IMM_W(IMM_W)) u_alu (
    .op  (op_ir),
    .a   (rd_a),
    .b   (rd_b),
    .imm (imm_ir),
    .y   (alu_y)
  );

  mc16_brcond #(.WIDTH(WORD_W)) u_br (
    .op   (op_ir),
    .val  (rd_c),
    .take (br_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_FETCH0;
      pc_q      <= '0;
      ir_q      <= '0;
      res_q     <= '0;
      take_q    <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      ph_q <= phase_e'(ph_q + 2'd1);
      unique case (ph_q)
        PH_FETCH0: begin
        end
        PH_FETCH1: begin
          ir_q <= mem_rdata;
          if (mem_op_in) mem_addr <= data_addr_in;
          if (store_in) begin
            mem_we    <= 1'b1;
            mem_wdata <= rd_c;
          end
        end
        PH_EXEC: begin
          mem_we <= 1'b0;
          res_q  <= alu_y;
          take_q <= br_take;
        end
        PH_COMMIT: begin
          pc_q     <= next_pc;
          mem_addr <= next_pc;
        end
      endcase
    end
  end

  // R11: the write strobe appears only in the operand phase
  p_we_in_exec_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ph_q == PH_EXEC));

  // R2: the fetch address is held through both fetch phases
  p_fetch_held_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FETCH1) |-> $stable(mem_addr));

  // R12: an untaken step advances by one, modulo 256
  p_pc_step_r12: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_COMMIT && !take_q) |=> (mem_addr == $past(pc_q) + 8'd1));

  // R7: a taken jump fetches from its immediate
  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_COMMIT && take_q) |=> (mem_addr == $past(ir_q[7:0])));
endmodule

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  always #2.5 clk = ~clk;

  mc16_core u_mc16_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // Synchronous RAM seen by the core
  logic [15:0] ram [256];
  always @(posedge clk) begin
    if (mem_we === 1'b1) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  // Reference model state
  logic [15:0] m_mem [256];
  logic [15:0] m_reg [16];
  logic [7:0]  m_pc;
  int          m_ph;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    ram[a]   = w;
    m_mem[a] = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      ram[i]   = 16'h0000;
      m_mem[i] = 16'h0000;
    end
  endtask

  task automatic model_reset();
    m_pc = 8'h00;
    m_ph = 0;
    for (int i = 0; i < 16; i++) m_reg[i] = 16'h0000;
  endtask

  task automatic model_exec(input logic [15:0] ins);
    logic [3:0]  op;
    logic [3:0]  d;
    logic [15:0] va, vb, vd, r;
    logic [7:0]  imm;
    bit          wr, tk;
    op  = ins[15:12];
    d   = ins[11:8];
    imm = ins[7:0];
    va  = m_reg[ins[7:4]];
    vb  = m_reg[ins[3:0]];
    vd  = m_reg[d];
    r   = 16'h0000;
    wr  = 0;
    tk  = 0;
    case (op)
      4'h0: begin r = va + vb; wr = 1; end
      4'h1: begin r = va - vb; wr = 1; end
      4'h2: begin r = va * vb; wr = 1; end
      4'h3: begin r = (vb == 0) ? 16'hFFFF : va / vb; wr = 1; end
      4'h4: begin r = va & vb; wr = 1; end
      4'h5: begin r = va | vb; wr = 1; end
      4'h6: begin r = ~(va ^ vb); wr = 1; end
      4'h7: begin r = {8'h00, imm}; wr = 1; end
      4'h8: tk = (vd == 0);
      4'h9: tk = (vd != 0);
      4'hA: tk = ($signed(vd) > 0);
      4'hB: tk = ($signed(vd) < 0);
      4'hC: begin r = m_mem[imm]; wr = 1; end
      4'hD: begin r = m_mem[vd[7:0]]; wr = 1; end
      4'hE: m_mem[imm] = vd;
      default: m_mem[vd[7:0]] = vd;
    endcase
    if (wr && d != 0) m_reg[d] = r;
    m_pc = tk ? imm : m_pc + 8'd1;
  endtask

  // Compare the port against the model for the current phase, then advance
  task automatic model_check();
    logic [15:0] ins;
    logic [3:0]  op;
    logic [7:0]  ea;
    logic [7:0]  exp_addr;
    logic        exp_we;
    ins = m_mem[m_pc];
    op  = ins[15:12];
    ea  = ins[12] ? m_reg[ins[11:8]][7:0] : ins[7:0];
    exp_addr = m_pc;
    exp_we   = 1'b0;
    if (m_ph >= 2 && op >= 4'hC) exp_addr = ea;
    if (m_ph == 2 && op >= 4'hE) exp_we = 1'b1;
    chk("R2/R7/R10/R12 mem_addr", {8'h00, mem_addr}, {8'h00, exp_addr});
    chk("R11 mem_we", {15'h0, mem_we}, {15'h0, exp_we});
    if (exp_we) chk("R11 mem_wdata", mem_wdata, m_reg[ins[11:8]]);
    if (m_ph == 3) model_exec(ins);
    m_ph = (m_ph + 1) % 4;
  endtask

  task automatic start_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic run_prog(input int ncyc);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 reset mem_addr", {8'h00, mem_addr}, 16'h0000);
    chk("R1 reset mem_we", {15'h0, mem_we}, 16'h0000);
    model_check();
    repeat (ncyc) begin
      @(posedge clk);
      @(negedge clk);
      model_check();
    end
  endtask

  task automatic load_prog_a();
    clear_mem();
    put(8'h00, 16'h7107); // R1 = 7
    put(8'h01, 16'h72FC); // R2 = 0xFC
    put(8'h02, 16'h0312); // R3 = R1+R2
    put(8'h03, 16'h1412); // R4 = R1-R2
    put(8'h04, 16'h2522); // R5 = R2*R2
    put(8'h05, 16'h2652); // R6 = R5*R2 (truncated)
    put(8'h06, 16'h3741); // R7 = R4/R1 unsigned
    put(8'h07, 16'h3810); // R8 = R1/R0 -> FFFF
    put(8'h08, 16'h4945); // R9 = R4&R5
    put(8'h09, 16'h5A12); // R10 = R1|R2
    put(8'h0A, 16'h6B12); // R11 = xnor
    put(8'h0B, 16'h0C40); // R12 = R4 + R0 (copy)
    put(8'h0C, 16'h7055); // write to R0, ignored
    put(8'h0D, 16'h0D01); // R13 = R0 + R1
    put(8'h0E, 16'hE343);
    put(8'h0F, 16'hE444);
    put(8'h10, 16'hE545);
    put(8'h11, 16'hE646);
    put(8'h12, 16'hE747);
    put(8'h13, 16'hE848);
    put(8'h14, 16'hE949);
    put(8'h15, 16'hEA4A);
    put(8'h16, 16'hEB4B);
    put(8'h17, 16'hEC4C);
    put(8'h18, 16'hED4D);
    put(8'h19, 16'h911C); // nonzero -> taken
    put(8'h1A, 16'h7E11); // skipped
    put(8'h1B, 16'hEE52); // skipped
    put(8'h1C, 16'hA41A); // R4 negative, not taken
    put(8'h1D, 16'hB420); // R4 negative, taken
    put(8'h1E, 16'h7E22);
    put(8'h1F, 16'hEE52);
    put(8'h20, 16'hA123); // R1 positive, taken
    put(8'h21, 16'h7E33);
    put(8'h22, 16'hEE52);
    put(8'h23, 16'h8521); // R5 nonzero, not taken
    put(8'h24, 16'hB121); // R1 positive, not taken
    put(8'h25, 16'h9021); // R0 zero, not taken
    put(8'h26, 16'h7E60); // R14 = 0x60
    put(8'h27, 16'hFE00); // mem[0x60] = R14
    put(8'h28, 16'h7F90); // R15 = 0x90
    put(8'h29, 16'hDF00); // R15 = mem[0x90]
    put(8'h2A, 16'hCE91); // R14 = mem[0x91]
    put(8'h2B, 16'hEF4F);
    put(8'h2C, 16'hEE4E);
    put(8'h2D, 16'hFF00); // mem[0x34] = R15
    put(8'h2E, 16'hC091); // load into R0, ignored
    put(8'h2F, 16'hE050); // mem[0x50] = R0
    put(8'h30, 16'h8030); // park
    put(8'h90, 16'h1234);
    put(8'h91, 16'hBEEF);
  endtask

  task automatic load_prog_b();
    clear_mem();
    put(8'h00, 16'h9310); // R3 cleared by reset -> not taken
    put(8'h01, 16'hE380); // mem[0x80] = R3
    put(8'h02, 16'h80FE); // always taken via R0
    put(8'hFE, 16'h7105); // R1 = 5
    put(8'hFF, 16'hE181); // mem[0x81] = R1, then PC wraps
  endtask

  initial begin
    start_reset();
    load_prog_a();
    run_prog(260);
    chk("R4 add/R6 zero-extended move", ram[8'h43], 16'h0103);
    chk("R4 sub", ram[8'h44], 16'hFF0B);
    chk("R4 mul", ram[8'h45], 16'hF810);
    chk("R4 mul low half", ram[8'h46], 16'h2FC0);
    chk("R5 unsigned div", ram[8'h47], 16'h246F);
    chk("R5 div by zero", ram[8'h48], 16'hFFFF);
    chk("R4 and", ram[8'h49], 16'hF800);
    chk("R4 or", ram[8'h4A], 16'h00FF);
    chk("R4 xnor", ram[8'h4B], 16'hFF04);
    chk("R8 copy via R0", ram[8'h4C], 16'hFF0B);
    chk("R9 R0 move ignored", ram[8'h4D], 16'h0007);
    chk("R7 skipped store", ram[8'h52], 16'h0000);
    chk("R10 indirect load", ram[8'h4F], 16'h1234);
    chk("R10 direct load", ram[8'h4E], 16'hBEEF);
    chk("R11 indirect store", ram[8'h60], 16'h0060);
    chk("R11 masked indirect store", ram[8'h34], 16'h1234);
    chk("R9 R0 load ignored", ram[8'h50], 16'h0000);
    chk("R3 register field decode", ram[8'h45] ^ ram[8'h49], 16'h0010);

    start_reset();
    load_prog_b();
    run_prog(120);
    chk("R13 registers cleared", ram[8'h80], 16'h0000);
    chk("R12 wrap program result", ram[8'h81], 16'h0005);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule